// File: doc/BRIEF.md
# Two-Layer Parallel Accumulate LDPC Encoder

This block produces a systematic LDPC codeword from an information word that is split into two halves, c1 (low half) and c2 (high half). Each half owns a layer of the parity-check matrix. Each layer has a sparse systematic part and a dual-diagonal parity part. Two differential accumulators, one per layer, compute the parity vectors p1 and p2 side by side, one parity bit each per clock. The serial parity latency is therefore half that of one accumulator chain for the same total parity length.

The layers are cross-coupled through identity link matrices. Check row i of layer 1 also covers bit i of c2, and check row i of layer 2 also covers bit i of c1. The sparse parts are fixed at elaboration time by a row rule. Each layer has a step and an offset: row r of a layer uses the columns (r + j*step + offset) mod KI/2 for j from 0 to ROW_W-1. With the parity count per layer equal to the half-word size, every column then has weight ROW_W, and no column has weight two for the default ROW_W of 3.

Software-free use: present a word on `info_i` and pulse `start_i` while the block is idle. Wait for the single-cycle `done_o`, then read `code_o`, which holds [c1 c2 p1 p2] until the next accepted start.

Top module: `ldpc2l_enc`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0 and `code_o` is all zeros.
- R2: A `start_i` sampled high while `busy_o` is 0 is accepted. At the next edge, `code_o[KI-1:0]` equals `info_i`, with c1 in bits KI/2-1:0 and c2 in bits KI-1:KI/2, and both parity fields are zero.
- R3: Layer-1 parity sits at `code_o[KI+i]`. It is p1[i] = p1[i-1] ^ c2[i] ^ XOR over j of c1[(i + j*STEP1 + OFS1) mod KI/2], with p1[-1] = 0.
- R4: Layer-2 parity sits at `code_o[KI+MP/2+i]`. It is p2[i] = p2[i-1] ^ c1[i] ^ XOR over j of c2[(i + j*STEP2 + OFS2) mod KI/2], with p2[-1] = 0.
- R5: `busy_o` stays high for exactly MP/2 cycles after an accepted start. `done_o` is a single-cycle pulse in the cycle after the last parity bit is written, with `busy_o` low.
- R6: `start_i` while `busy_o` is 1 has no effect: the codeword under construction and the done timing are unchanged.
- R7: Every finished codeword satisfies all MP checks of both layers over GF(2), where each layer's check i sums its row taps, its link bit, p[i] and p[i-1].
- R8: After `done_o`, `code_o` holds its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin encoding `info_i` (accepted only when idle) |
| info_i | input | KI | Information word, c1 in the low half |
| busy_o | output | 1 | Accumulators are stepping |
| done_o | output | 1 | One-cycle pulse when the codeword is complete |
| code_o | output | KI+MP | Codeword {p2, p1, c2, c1} |

## Verification
The in-RTL properties take for granted that `info_i` need only be valid in the cycle where `start_i` is accepted. They also assume a start raised mid-run is legal and must be dropped. The accumulator property assumes rows are visited strictly in ascending order from zero, which the controller guarantees and checks. The stimulus always holds `info_i` steady around the accepting edge. It drives starts only from the falling clock edge. It deliberately raises `start_i` with a different word in the middle of a run, so the dropped-start path is exercised at the ports.

// File: rtl/ldpc2l_pkg.sv
package ldpc2l_pkg;

   // Column index of tap j on row r of a layer's sparse part.
   function automatic int h_col(input int r, input int j, input int step,
                                input int ofs, input int kh);
      return (r + j * step + ofs) % kh;
   endfunction

   // Log2 ceiling, at least 1, for counter widths.
   function automatic int cnt_w(input int n);
      int w;
      w = 1;
      while ((1 << w) < n) w++;
      return w;
   endfunction

endpackage

// File: rtl/ldpc2l_proj.sv
module ldpc2l_proj #(
   parameter int KH    = 16,
   parameter int MH    = 16,
   parameter int ROW_W = 3,
   parameter int STEP  = 5,
   parameter int OFS   = 0,
   localparam int RW   = ldpc2l_pkg::cnt_w(MH)
) (
   input  logic [KH-1:0] own_i,
   input  logic [KH-1:0] other_i,
   input  logic [RW-1:0] row_i,
   output logic          bit_o
);
   logic [MH-1:0] row_bits;

   for (genvar r = 0; r < MH; r++) begin : g_row
      logic [ROW_W-1:0] taps;
      for (genvar j = 0; j < ROW_W; j++) begin : g_tap
         localparam int COL = ldpc2l_pkg::h_col(r, j, STEP, OFS, KH);
         assign taps[j] = own_i[COL];
      end
      // identity link: row r also covers bit r of the other half
      assign row_bits[r] = (^taps) ^ other_i[r];
   end

   always_comb begin
      bit_o = 1'b0;
      for (int r = 0; r < MH; r++)
         if (row_i == RW'(r)) bit_o = row_bits[r];
   end

endmodule

// File: rtl/ldpc2l_acc.sv
module ldpc2l_acc #(
   parameter int MH  = 16,
   localparam int RW = ldpc2l_pkg::cnt_w(MH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          en_i,
   input  logic [RW-1:0] row_i,
   input  logic          proj_i,
   output logic [MH-1:0] par_o
);
   logic [MH-1:0] par_q;
   logic          acc_q;
   logic          nxt;

   assign nxt = acc_q ^ proj_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         par_q <= '0;
         acc_q <= 1'b0;
      end else if (clr_i) begin
         par_q <= '0;
         acc_q <= 1'b0;
      end else if (en_i) begin
         for (int r = 0; r < MH; r++)
            if (row_i == RW'(r)) par_q[r] <= nxt;
         acc_q <= nxt;
      end
   end

   assign par_o = par_q;

   // R2: a clear leaves an empty accumulator and parity field
   a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (acc_q == 1'b0) && (par_q == '0));

   // R3 / R4: the running bit always equals the previous parity bit
   a_r3_running_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && row_i != '0 && !clr_i) |-> acc_q == par_q[row_i - RW'(1)]);

   // R4: first row starts from zero
   a_r4_first_row_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && row_i == '0 && !clr_i) |-> acc_q == 1'b0);

endmodule

// File: rtl/ldpc2l_ctrl.sv
module ldpc2l_ctrl #(
   parameter int MH  = 16,
   localparam int RW = ldpc2l_pkg::cnt_w(MH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   output logic          load_o,
   output logic          step_o,
   output logic [RW-1:0] row_o,
   output logic          busy_o,
   output logic          done_o
);
   logic          busy_q;
   logic          done_q;
   logic [RW-1:0] row_q;
   logic          last;

   assign last   = (row_q == RW'(MH - 1));
   assign load_o = start_i && !busy_q;
   assign step_o = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         row_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (load_o) begin
            busy_q <= 1'b1;
            row_q  <= '0;
         end else if (busy_q) begin
            if (last) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               row_q  <= '0;
            end else begin
               row_q <= row_q + RW'(1);
            end
         end
      end
   end

   assign row_o  = row_q;
   assign busy_o = busy_q;
   assign done_o = done_q;

   // R5: done is a single pulse
   a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R5: finishing the last row raises done and drops busy
   a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && last) |=> (done_q && !busy_q));

   // R6: a start during a run does not rewind the row counter
   a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !last && start_i) |=> (busy_q && row_q == $past(row_q) + RW'(1)));

   // R5: done never overlaps busy
   a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !busy_q);

endmodule

// File: rtl/ldpc2l_enc.sv
module ldpc2l_enc #(
   parameter int KI    = 32,
   parameter int MP    = 32,
   parameter int ROW_W = 3,
   parameter int STEP1 = 5,
   parameter int OFS1  = 0,
   parameter int STEP2 = 3,
   parameter int OFS2  = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [KI-1:0]    info_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [KI+MP-1:0] code_o
);
   localparam int KH = KI / 2;
   localparam int MH = MP / 2;
   localparam int RW = ldpc2l_pkg::cnt_w(MH);

   // elaboration-time parameter checks
   if (KI % 2 != 0 || MP % 2 != 0) begin : g_bad_even
      $error("KI and MP must be even");
   end
   if (MH > KH || MH < 2) begin : g_bad_link
      $error("identity links need 2 <= MP/2 <= KI/2");
   end
   if (ROW_W < 1 || ROW_W > 4) begin : g_bad_roww
      $error("ROW_W must be 1..4");
   end
   if ((ROW_W - 1) * STEP1 >= KH || (ROW_W - 1) * STEP2 >= KH ||
       STEP1 < 1 || STEP2 < 1) begin : g_bad_step
      $error("row taps must be distinct columns");
   end

   logic          load;
   logic          step;
   logic [RW-1:0] row;
   logic [KI-1:0] info_q;
   logic          pj1, pj2;
   logic [MH-1:0] par1, par2;

   ldpc2l_ctrl #(.MH(MH)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(start_i),
      .load_o (load),
      .step_o (step),
      .row_o  (row),
      .busy_o (busy_o),
      .done_o (done_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    info_q <= '0;
      else if (load) info_q <= info_i;
   end

   ldpc2l_proj #(.KH(KH), .MH(MH), .ROW_W(ROW_W), .STEP(STEP1), .OFS(OFS1)) u_proj1 (
      .own_i  (info_q[KH-1:0]),
      .other_i(info_q[KI-1:KH]),
      .row_i  (row),
      .bit_o  (pj1)
   );

   ldpc2l_proj #(.KH(KH), .MH(MH), .ROW_W(ROW_W), .STEP(STEP2), .OFS(OFS2)) u_proj2 (
      .own_i  (info_q[KI-1:KH]),
      .other_i(info_q[KH-1:0]),
      .row_i  (row),
      .bit_o  (pj2)
   );

   ldpc2l_acc #(.MH(MH)) u_acc1 (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (load),
      .en_i  (step),
      .row_i (row),
      .proj_i(pj1),
      .par_o (par1)
   );

   ldpc2l_acc #(.MH(MH)) u_acc2 (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (load),
      .en_i  (step),
      .row_i (row),
      .proj_i(pj2),
      .par_o (par2)
   );

   assign code_o = {par2, par1, info_q};

   // R8: the information field only changes on an accepted start
   a_r8_info_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(info_q));

   // R8: nothing moves while idle without a start
   a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !load) |=> $stable(code_o));

endmodule

// File: tb/ldpc2l_enc_tb.sv
module ldpc2l_enc_tb;
   localparam int KI = 32, MP = 32, ROW_W = 3;
   localparam int STEP1 = 5, OFS1 = 0, STEP2 = 3, OFS2 = 7;
   localparam int KH = KI / 2, MH = MP / 2, N = KI + MP;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [KI-1:0] info_i = '0;
   logic          busy_o, done_o;
   logic [N-1:0]  code_o;

   int checks = 0;
   int fails  = 0;
   bit ended  = 0;
   logic [N-1:0] expq[$];
   logic [N-1:0] last_exp;

   always #2.5 clk = ~clk;

   ldpc2l_enc #(.KI(KI), .MP(MP), .ROW_W(ROW_W), .STEP1(STEP1), .OFS1(OFS1),
                .STEP2(STEP2), .OFS2(OFS2)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .info_i(info_i),
      .busy_o(busy_o), .done_o(done_o), .code_o(code_o));

   function automatic logic [N-1:0] model(input logic [KI-1:0] c);
      logic [MH-1:0] p1, p2;
      logic a1, a2, t1, t2;
      a1 = 0; a2 = 0;
      for (int i = 0; i < MH; i++) begin
         t1 = c[KH + i];
         t2 = c[i];
         for (int j = 0; j < ROW_W; j++) begin
            t1 ^= c[ldpc2l_pkg::h_col(i, j, STEP1, OFS1, KH)];
            t2 ^= c[KH + ldpc2l_pkg::h_col(i, j, STEP2, OFS2, KH)];
         end
         a1 ^= t1; a2 ^= t2;
         p1[i] = a1; p2[i] = a2;
      end
      return {p2, p1, c};
   endfunction

   // number of violated checks of H x^T = 0
   function automatic int syndrome(input logic [N-1:0] x);
      int bad;
      logic s1, s2;
      bad = 0;
      for (int i = 0; i < MH; i++) begin
         s1 = x[KH + i] ^ x[KI + i] ^ ((i > 0) ? x[KI + i - 1] : 1'b0);
         s2 = x[i] ^ x[KI + MH + i] ^ ((i > 0) ? x[KI + MH + i - 1] : 1'b0);
         for (int j = 0; j < ROW_W; j++) begin
            s1 ^= x[ldpc2l_pkg::h_col(i, j, STEP1, OFS1, KH)];
            s2 ^= x[KH + ldpc2l_pkg::h_col(i, j, STEP2, OFS2, KH)];
         end
         bad += int'(s1) + int'(s2);
      end
      return bad;
   endfunction

   task automatic check(input bit ok, input string req, input logic [N-1:0] act,
                        input logic [N-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_test();
      if (!ended) begin
         ended = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   // monitor: compares every finished codeword with the scoreboard
   always @(negedge clk) begin
      if (rst_n && done_o) begin
         if (expq.size() == 0) begin
            check(0, "R5 unexpected done", code_o, '0);
         end else begin
            last_exp = expq.pop_front();
            check(code_o[KI+MH-1:KI] == last_exp[KI+MH-1:KI], "R3 p1", code_o, last_exp);
            check(code_o[N-1:KI+MH] == last_exp[N-1:KI+MH], "R4 p2", code_o, last_exp);
            check(syndrome(code_o) == 0, "R7 syndrome", code_o, last_exp);
            check(busy_o == 1'b0, "R5 busy low at done", N'(busy_o), '0);
         end
      end
   end

   // driver: pushes the expectation, starts, and times the run
   task automatic encode(input logic [KI-1:0] w, input bit poke);
      int n;
      @(negedge clk);
      while (busy_o) @(negedge clk);
      expq.push_back(model(w));
      info_i  = w;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      // R2: systematic field loaded, parity fields clear
      check(code_o == {{MP{1'b0}}, w}, "R2 load", code_o, {{MP{1'b0}}, w});
      n = 1;
      while (!done_o) begin
         if (poke && n == 4) begin
            // R6: start with a different word mid-run
            info_i  = ~w;
            start_i = 1'b1;
         end else begin
            start_i = 1'b0;
         end
         check(busy_o == 1'b1, "R5 busy during run", N'(busy_o), N'(1));
         @(negedge clk);
         n++;
         if (n > MH + 4) break;
      end
      start_i = 1'b0;
      check(n == MH + 1, "R5 done timing", N'(n), N'(MH + 1));
      if (poke)
         check(code_o[KI-1:0] == w, "R6 ignored start", code_o, {{MP{1'b0}}, w});
      // R8: held afterwards
      repeat (3) @(negedge clk);
      check(code_o == model(w), "R8 hold", code_o, model(w));
   endtask

   initial begin
      #200000;
      check(0, "watchdog", '0, '0);
      finish_test();
   end

   initial begin
      logic [KI-1:0] w;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(busy_o == 0 && done_o == 0 && code_o == '0, "R1 reset", code_o, '0);
      rst_n = 1'b1;
      @(negedge clk);
      encode('0, 0);
      encode('1, 0);
      encode(KI'(1), 0);               // single c1 bit
      encode(KI'(1) << (KI - 1), 0);   // single c2 bit (top)
      encode(KI'(32'h0001_8000), 0);   // half-boundary bits
      encode(KI'(32'hA5C3_3C5A), 1);   // R6 mid-run start
      for (int k = 0; k < 10; k++) begin
         w = KI'($urandom());
         encode(w, (k % 3) == 0);
      end
      repeat (4) @(negedge clk);
      check(expq.size() == 0, "R5 scoreboard drained", N'(expq.size()), '0);
      finish_test();
   end

endmodule